// File: doc/BRIEF.md
# Flash In-Application Programming Command Controller

This block is the special-function-register front end that lets an 8051-style core run flash operations from its own program. The core reaches four byte registers over a simple write/read port: a configuration register, a command register and two address bytes. A write to the command register is screened. It must have in-application programming enabled, the controller must be idle, and the opcode must be implemented. If the write passes, the block issues a one-cycle start request to the flash engine, carrying the opcode and the 16-bit address.

The flash engine answers with a one-cycle done pulse, which ends the busy period. When the flash interrupt enable is set, completion of any command other than byte verify raises a level flag. While that enable is set, the flag replaces the external INT1 pin on the interrupt line to the core. Byte verify finishes by itself one cycle after its start and never raises the flag. The configuration register also gives a one-cycle software-reset request and a program-memory block-select level.

Top module: `iap_cmd_ctrl`

## Requirements
- R1: After reset, all four registers read 00h. `fl_start`, `busy` and `swr_req` are 0. `bank_sel` is 0 and `int1_n` follows `ext_int1_n`.
- R2: The configuration register (B1h) stores bit 6 as the enable and bit 0 as the block select. On read, all other bits return 0. `bank_sel` follows bit 0.
- R3: Writing B1h with bit 1 set makes `swr_req` high for exactly the one cycle after the write. Bit 1 always reads back 0.
- R4: The address-low register (B3h) and address-high register (B4h) are read/write. `fl_addr` equals {B4h, B3h}.
- R5: While the enable bit is 0, a write to the command register (B2h) is ignored: the register keeps its value and no start is issued.
- R6: An accepted write of an implemented opcode in bits 6:0 makes `fl_start` high for the one cycle after the write. `fl_op` then equals the opcode and `busy` is 1. The implemented opcodes are 01h, 03h, 05h, 08h, 09h, 0Bh, 0Ch, 0Dh, 0Eh and 0Fh.
- R7: A write of any other opcode issues no start and leaves `busy` at 0.
- R8: For opcodes other than 0Ch, `busy` stays 1 until the cycle after a `fl_done` pulse. While busy, command writes are ignored: no start is issued and the readback is unchanged.
- R9: When the command register bit 7 (interrupt enable) is 1, completion of a non-verify command drives `int1_n` low, and `ext_int1_n` is ignored.
- R10: When bit 7 is 0, `int1_n` equals `ext_int1_n`.
- R11: Byte verify (0Ch) clears `busy` one cycle after its start without waiting for `fl_done`. It never drives `int1_n` low, even when bit 7 is 1.
- R12: An accepted command write clears the completion flag, which releases `int1_n` when bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | AW | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| fl_start | output | 1 | One-cycle flash operation request |
| fl_op | output | 7 | Operation code |
| fl_addr | output | 16 | Operation address |
| fl_done | input | 1 | Flash operation finished |
| busy | output | 1 | Operation in progress |
| ext_int1_n | input | 1 | External interrupt pin, active low |
| int1_n | output | 1 | Interrupt line to the core, active low |
| swr_req | output | 1 | Software reset request pulse |
| bank_sel | output | 1 | Program-memory block select |

## Verification
The bench builds the block with its default parameters: an 8-bit register address, the four registers at B1h to B4h, and 0Ch as the verify opcode. With this map, a single vector table can sweep every implemented opcode and a set of reserved neighbours through the real address decode. The verify special case and the interrupt takeover can also be reached with the encodings stated in the requirements.

// File: rtl/iap_cmd_ctrl.sv
module iap_cmd_ctrl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CFG_ADR = 8'hB1,
  parameter logic [AW-1:0] CMD_ADR = 8'hB2,
  parameter logic [AW-1:0] ADL_ADR = 8'hB3,
  parameter logic [AW-1:0] ADH_ADR = 8'hB4,
  parameter logic [6:0]    OP_VERIFY = 7'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfr_wr,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  output logic          fl_start,
  output logic [6:0]    fl_op,
  output logic [15:0]   fl_addr,
  input  logic          fl_done,
  output logic          busy,
  input  logic          ext_int1_n,
  output logic          int1_n,
  output logic          swr_req,
  output logic          bank_sel
);

  logic       iap_en, fie, vrf, cmpl;
  logic [6:0] op;
  logic [7:0] adl, adh;

  function automatic logic op_known(input logic [6:0] c);
    case (c)
      7'h01, 7'h03, 7'h05, 7'h08, 7'h09,
      7'h0B, 7'h0C, 7'h0D, 7'h0E, 7'h0F: op_known = 1'b1;
      default:                           op_known = 1'b0;
    endcase
  endfunction

  wire wr_cfg = sfr_wr && sfr_addr == CFG_ADR;
  wire wr_cmd = sfr_wr && sfr_addr == CMD_ADR;
  wire wr_adl = sfr_wr && sfr_addr == ADL_ADR;
  wire wr_adh = sfr_wr && sfr_addr == ADH_ADR;
  wire cmd_ok = wr_cmd && iap_en && !busy;
  wire go     = cmd_ok && op_known(sfr_wdata[6:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iap_en <= 1'b0; bank_sel <= 1'b0; swr_req <= 1'b0;
      fie <= 1'b0; op <= '0; adl <= '0; adh <= '0;
      busy <= 1'b0; vrf <= 1'b0; cmpl <= 1'b0; fl_start <= 1'b0;
    end else begin
      swr_req  <= wr_cfg && sfr_wdata[1];
      fl_start <= go;
      if (wr_cfg) begin
        iap_en   <= sfr_wdata[6];
        bank_sel <= sfr_wdata[0];
      end
      if (wr_adl) adl <= sfr_wdata;
      if (wr_adh) adh <= sfr_wdata;
      if (cmd_ok) begin
        fie  <= sfr_wdata[7];
        op   <= sfr_wdata[6:0];
        cmpl <= 1'b0;
      end
      if (go) begin
        busy <= 1'b1;
        vrf  <= sfr_wdata[6:0] == OP_VERIFY;
      end else if (busy && (vrf || fl_done)) begin
        busy <= 1'b0;
        if (!vrf) cmpl <= 1'b1;
      end
    end
  end

  assign fl_op   = op;
  assign fl_addr = {adh, adl};
  assign int1_n  = fie ? ~cmpl : ext_int1_n;

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == CFG_ADR)      sfr_rdata = {1'b0, iap_en, 5'b0, bank_sel};
    else if (sfr_addr == CMD_ADR) sfr_rdata = {fie, op};
    else if (sfr_addr == ADL_ADR) sfr_rdata = adl;
    else if (sfr_addr == ADH_ADR) sfr_rdata = adh;
  end

  p_swr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swr_req |=> !swr_req);
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> busy);
  p_need_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(iap_en));
  p_verify_short_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_op == OP_VERIFY) |=> !busy);
  p_op_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fl_start) |-> $stable(fl_op));
  p_cmpl_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl) |-> $past(fl_done));

endmodule

// File: tb/iap_cmd_ctrl_test.sv
module iap_cmd_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic sfr_wr = 0, fl_done = 0, ext_int1_n = 1;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic [7:0] sfr_rdata;
  logic fl_start, busy, int1_n, swr_req, bank_sel;
  logic [6:0] fl_op;
  logic [15:0] fl_addr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  iap_cmd_ctrl uut (.clk, .rst_n, .sfr_wr, .sfr_addr, .sfr_wdata, .sfr_rdata,
    .fl_start, .fl_op, .fl_addr, .fl_done, .busy, .ext_int1_n, .int1_n,
    .swr_req, .bank_sel);

  localparam logic [7:0] VEC [16] = '{
    8'h81, 8'h8B, 8'h8D, 8'h8C, 8'h8E, 8'h8F, 8'h83, 8'h85,
    8'h89, 8'h88, 8'h00, 8'h02, 8'h7F, 8'h0A, 8'h04, 8'h10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; #1 d = sfr_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); fl_done = 1;
    @(negedge clk); fl_done = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 8'hB1; a <= 8'hB4; a++) begin rd(a[7:0], d); chk("R1 reg", d, 0); end
    chk("R1 start", fl_start, 0); chk("R1 busy", busy, 0);
    chk("R1 swr", swr_req, 0); chk("R1 bsel", bank_sel, 0);
    ext_int1_n = 0; #1 chk("R1 int", int1_n, 0); ext_int1_n = 1; #1;
    // R5 disabled command write
    wr(8'hB2, 8'h8E);
    chk("R5 start", fl_start, 0);
    rd(8'hB2, d); chk("R5 readback", d, 0); chk("R5 busy", busy, 0);
    // R2, R3 configuration
    wr(8'hB1, 8'hFF);
    chk("R3 swr pulse", swr_req, 1);
    @(negedge clk); chk("R3 swr one cycle", swr_req, 0);
    rd(8'hB1, d); chk("R2 cfg readback", d, 8'h41); chk("R2 bsel", bank_sel, 1);
    wr(8'hB1, 8'h40);
    chk("R2 bsel clear", bank_sel, 0);
    // R4 address
    wr(8'hB3, 8'h5A); wr(8'hB4, 8'hC3);
    chk("R4 fl_addr", fl_addr, 16'hC35A);
    rd(8'hB4, d); chk("R4 high", d, 8'hC3);
    // opcode table: R6, R7, R8, R11
    foreach (VEC[i]) begin
      logic [6:0] opc;
      opc = VEC[i][6:0];
      wr(8'hB2, {1'b0, opc});
      chk(VEC[i][7] ? "R6 start" : "R7 no start", fl_start, VEC[i][7]);
      chk(VEC[i][7] ? "R6 busy" : "R7 busy", busy, VEC[i][7]);
      if (VEC[i][7]) begin
        chk("R6 op", fl_op, opc);
        if (opc == 7'h0C) begin
          @(negedge clk); chk("R11 verify self-clears", busy, 0);
        end else begin
          @(negedge clk); chk("R8 waits done", busy, 1);
          done_pulse(); chk("R8 done clears", busy, 0);
        end
      end
    end
    // R8 write while busy ignored
    wr(8'hB2, 8'h0E);
    wr(8'hB2, 8'h01);
    chk("R8 no restart", fl_start, 0);
    rd(8'hB2, d); chk("R8 readback", d, 8'h0E);
    done_pulse();
    // R10 pass-through with FIE 0 after completion
    ext_int1_n = 0; #1 chk("R10 pass low", int1_n, 0);
    ext_int1_n = 1; #1 chk("R10 pass high", int1_n, 1);
    // R9 interrupt takeover
    wr(8'hB2, 8'h8B);
    chk("R9 idle int", int1_n, 1);
    done_pulse();
    chk("R9 int asserted", int1_n, 0);
    ext_int1_n = 1; #1 chk("R9 ext ignored", int1_n, 0);
    // R12 clear on accepted write; R11 verify no interrupt
    wr(8'hB2, 8'h8C);
    chk("R12 flag cleared", int1_n, 1);
    ext_int1_n = 0;
    repeat (3) @(negedge clk);
    fl_done = 1; @(negedge clk); fl_done = 0;
    chk("R11 no int", int1_n, 1);
    ext_int1_n = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule